// File: doc/BRIEF.md
# Reversible Toffoli Cascade Evaluator with Fault Injection

This block evaluates a programmable chain of reversible multi-control Toffoli gates acting on a bundle of binary lines. Each gate slot holds a control mask, a single target line and an enable bit. A gate flips its target line only when every line in its control mask is 1. With an empty mask it is a plain inverter, with one control it is a controlled NOT, and with two controls it is a two-control Toffoli. Slots are applied in ascending slot order, and control lines always pass through a gate unchanged.

Next to the fault-free chain, a second copy of the same chain can carry one injected fault. The supported faults are: one gate removed, one gate applied several times back to back, some control nodes of one gate removed, or a run of consecutive gates removed. For every applied input vector the block returns both results and a registered mismatch flag. A test engine uses this to judge whether a candidate vector exposes a given fault.

Top module: `revgate_cascade`

## Requirements
- R1: An enabled slot flips its target line exactly when every line set in its control mask is 1 in the vector reaching it. An empty mask flips the target unconditionally. Other lines pass unchanged. Slots act in order 0, 1, ..., NG-1.
- R2: After a synchronous reset, every slot is disabled, the fault mode is none, and out_valid, mismatch, config_error, golden_vec and faulty_vec are all 0. A disabled slot passes its input through unchanged.
- R3: A configuration write (cfg_we high) of slot cfg_slot takes effect for vectors applied from the next cycle. If bit cfg_target of cfg_ctrl_mask is 1, the write is rejected, the slot keeps its old contents, and config_error is 1 from the next cycle. config_error returns to 0 after the next accepted write.
- R4: A vector applied with in_valid appears on golden_vec and faulty_vec, with out_valid high, one cycle later. The data outputs hold their values while in_valid is low. mismatch is 1 exactly when out_valid is 1 and the two results differ.
- R5: A fault write (flt_we) loads flt_mode, flt_gate, flt_param and flt_drop, effective from the next cycle. Mode code 0 means no fault, and codes 5 to 7 also behave as no fault: in these cases faulty_vec equals golden_vec.
- R6: Mode code 1 removes slot flt_gate from the faulty chain.
- R7: Mode code 2 applies slot flt_gate N times in a row in the faulty chain. N is flt_param clamped to the range 2..4.
- R8: Mode code 3 removes from slot flt_gate, in the faulty chain only, every control line set in flt_drop.
- R9: Mode code 4 removes slots flt_gate to flt_gate+N-1 from the faulty chain, where N is flt_param with a minimum of 2. The run stops at the last slot.
- R10: golden_vec never depends on the fault settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Gate slot write strobe |
| cfg_slot | input | 4 | Slot written |
| cfg_ctrl_mask | input | 8 | Control line mask |
| cfg_target | input | 3 | Target line index |
| cfg_enable | input | 1 | Slot enable |
| flt_we | input | 1 | Fault setting write strobe |
| flt_mode | input | 3 | Fault mode code (0 none, 1 gate removed, 2 gate repeated, 3 controls removed, 4 run removed) |
| flt_gate | input | 4 | Faulty slot or first slot of the removed run |
| flt_param | input | 5 | Repeat count or run length |
| flt_drop | input | 8 | Control lines removed in mode 3 |
| in_valid | input | 1 | Input vector valid |
| in_vec | input | 8 | Input vector |
| out_valid | output | 1 | Result valid |
| golden_vec | output | 8 | Fault-free result |
| faulty_vec | output | 8 | Result with injected fault |
| mismatch | output | 1 | Results differ |
| config_error | output | 1 | Last configuration write was rejected |

## Verification
The hardest situations to reach are the fault-window edges. These are a repeated gate whose count is even, where the gate cancels itself, or odd, where it acts once. They also include repeat and run parameters outside their legal range, and a removed run that would reach past the last slot. The bench reaches these by loading a fixed chain and sweeping all 256 input vectors under each fault setting, including parameters 0, 1 and 7 and a run that starts at slot 14. It then repeats the sweeps over random chains, so every vector is compared against a behavioural model that evaluates both chains with plain loops.

// File: rtl/revgate_pkg.sv
package revgate_pkg;

  typedef enum logic [2:0] {
    FM_NONE      = 3'd0,
    FM_DROP_ONE  = 3'd1,
    FM_REPEAT    = 3'd2,
    FM_DROP_CTRL = 3'd3,
    FM_DROP_RUN  = 3'd4
  } fault_mode_e;

endpackage

// File: rtl/revgate_cfg_store.sv
module revgate_cfg_store #(
  parameter int NL = 8,
  parameter int NG = 16,
  localparam int TGT_W = $clog2(NL),
  localparam int GIDX_W = $clog2(NG)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [GIDX_W-1:0]             slot,
  input  logic [NL-1:0]                 ctrl_mask,
  input  logic [TGT_W-1:0]              target,
  input  logic                          enable,
  output logic [NG-1:0][NL-1:0]         mask_q,
  output logic [NG-1:0][TGT_W-1:0]      tgt_q,
  output logic [NG-1:0]                 en_q,
  output logic                          err_q
);

  logic overlap;
  assign overlap = ctrl_mask[target];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      tgt_q  <= '0;
      en_q   <= '0;
      err_q  <= 1'b0;
    end else if (we) begin
      err_q <= overlap;
      if (!overlap) begin
        mask_q[slot] <= ctrl_mask;
        tgt_q[slot]  <= target;
        en_q[slot]   <= enable;
      end
    end
  end

endmodule

// File: rtl/revgate_fault_ctl.sv
module revgate_fault_ctl
  import revgate_pkg::*;
#(
  parameter int NL = 8,
  parameter int NG = 16,
  parameter int MAXREP = 4,
  localparam int GIDX_W = $clog2(NG),
  localparam int PAR_W = GIDX_W + 1,
  localparam int REP_W = $clog2(MAXREP + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [2:0]                mode,
  input  logic [GIDX_W-1:0]         gate,
  input  logic [PAR_W-1:0]          param,
  input  logic [NL-1:0]             drop,
  output logic [NG-1:0]             skip,
  output logic [NG-1:0][REP_W-1:0]  reps,
  output logic [NG-1:0][NL-1:0]     drop_ctl
);

  fault_mode_e         mode_q;
  logic [GIDX_W-1:0]   gate_q;
  logic [PAR_W-1:0]    param_q;
  logic [NL-1:0]       drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= FM_NONE;
      gate_q  <= '0;
      param_q <= '0;
      drop_q  <= '0;
    end else if (we) begin
      mode_q  <= fault_mode_e'(mode);
      gate_q  <= gate;
      param_q <= param;
      drop_q  <= drop;
    end
  end

  logic [REP_W-1:0] rep_n;
  logic [PAR_W-1:0] run_len;
  logic [PAR_W:0]   run_end;

  always_comb begin
    if (param_q < PAR_W'(2))
      rep_n = REP_W'(2);
    else if (param_q > PAR_W'(MAXREP))
      rep_n = REP_W'(MAXREP);
    else
      rep_n = REP_W'(param_q);
    run_len = (param_q < PAR_W'(2)) ? PAR_W'(2) : param_q;
    run_end = (PAR_W + 1)'(gate_q) + (PAR_W + 1)'(run_len);
  end

  for (genvar g = 0; g < NG; g++) begin : g_slot
    logic hit;
    logic in_run;
    assign hit    = (gate_q == GIDX_W'(g));
    assign in_run = ((PAR_W + 1)'(g) >= (PAR_W + 1)'(gate_q)) &&
                    ((PAR_W + 1)'(g) < run_end);
    assign skip[g]     = (mode_q == FM_DROP_ONE && hit) ||
                         (mode_q == FM_DROP_RUN && in_run);
    assign reps[g]     = (mode_q == FM_REPEAT && hit) ? rep_n : REP_W'(1);
    assign drop_ctl[g] = (mode_q == FM_DROP_CTRL && hit) ? drop_q : '0;
  end

endmodule

// File: rtl/revgate_chain.sv
module revgate_chain #(
  parameter int NL = 8,
  parameter int NG = 16,
  parameter int MAXREP = 4,
  localparam int TGT_W = $clog2(NL),
  localparam int REP_W = $clog2(MAXREP + 1)
) (
  input  logic [NG-1:0][NL-1:0]     mask,
  input  logic [NG-1:0][TGT_W-1:0]  tgt,
  input  logic [NG-1:0]             en,
  input  logic [NG-1:0]             skip,
  input  logic [NG-1:0][REP_W-1:0]  reps,
  input  logic [NG-1:0][NL-1:0]     drop,
  input  logic [NL-1:0]             din,
  output logic [NL-1:0]             dout
);

  function automatic logic [NL-1:0] apply_gate(input logic [NL-1:0] v,
                                                input logic [NL-1:0] cm,
                                                input logic [TGT_W-1:0] t);
    logic [NL-1:0] flip;
    flip = ((v & cm) == cm) ? (NL'(1) << t) : '0;
    return v ^ flip;
  endfunction

  logic [NL-1:0] stg [NG+1];
  assign stg[0] = din;

  for (genvar g = 0; g < NG; g++) begin : g_slot
    logic [NL-1:0] sub [MAXREP+1];
    logic [NL-1:0] cm;
    assign cm     = mask[g] & ~drop[g];
    assign sub[0] = stg[g];
    for (genvar r = 0; r < MAXREP; r++) begin : g_rep
      assign sub[r+1] = (reps[g] > REP_W'(r)) ? apply_gate(sub[r], cm, tgt[g]) : sub[r];
    end
    assign stg[g+1] = (en[g] && !skip[g]) ? sub[MAXREP] : stg[g];
  end

  assign dout = stg[NG];

endmodule

// File: rtl/revgate_cascade.sv
module revgate_cascade #(
  parameter int NL = 8,
  parameter int NG = 16,
  parameter int MAXREP = 4,
  localparam int TGT_W = $clog2(NL),
  localparam int GIDX_W = $clog2(NG),
  localparam int PAR_W = GIDX_W + 1,
  localparam int REP_W = $clog2(MAXREP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [GIDX_W-1:0] cfg_slot,
  input  logic [NL-1:0]     cfg_ctrl_mask,
  input  logic [TGT_W-1:0]  cfg_target,
  input  logic              cfg_enable,
  input  logic              flt_we,
  input  logic [2:0]        flt_mode,
  input  logic [GIDX_W-1:0] flt_gate,
  input  logic [PAR_W-1:0]  flt_param,
  input  logic [NL-1:0]     flt_drop,
  input  logic              in_valid,
  input  logic [NL-1:0]     in_vec,
  output logic              out_valid,
  output logic [NL-1:0]     golden_vec,
  output logic [NL-1:0]     faulty_vec,
  output logic              mismatch,
  output logic              config_error
);

  logic [NG-1:0][NL-1:0]     mask_q;
  logic [NG-1:0][TGT_W-1:0]  tgt_q;
  logic [NG-1:0]             en_q;
  logic [NG-1:0]             f_skip;
  logic [NG-1:0][REP_W-1:0]  f_reps;
  logic [NG-1:0][NL-1:0]     f_drop;
  logic [NG-1:0][REP_W-1:0]  one_reps;
  logic [NL-1:0]             gold_d;
  logic [NL-1:0]             faul_d;

  for (genvar g = 0; g < NG; g++) begin : g_one
    assign one_reps[g] = REP_W'(1);
  end

  revgate_cfg_store #(.NL(NL), .NG(NG)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .slot(cfg_slot),
    .ctrl_mask(cfg_ctrl_mask), .target(cfg_target), .enable(cfg_enable),
    .mask_q(mask_q), .tgt_q(tgt_q), .en_q(en_q), .err_q(config_error)
  );

  revgate_fault_ctl #(.NL(NL), .NG(NG), .MAXREP(MAXREP)) u_flt (
    .clk(clk), .rst(rst), .we(flt_we), .mode(flt_mode), .gate(flt_gate),
    .param(flt_param), .drop(flt_drop),
    .skip(f_skip), .reps(f_reps), .drop_ctl(f_drop)
  );

  revgate_chain #(.NL(NL), .NG(NG), .MAXREP(MAXREP)) u_gold (
    .mask(mask_q), .tgt(tgt_q), .en(en_q),
    .skip('0), .reps(one_reps), .drop('0),
    .din(in_vec), .dout(gold_d)
  );

  revgate_chain #(.NL(NL), .NG(NG), .MAXREP(MAXREP)) u_faul (
    .mask(mask_q), .tgt(tgt_q), .en(en_q),
    .skip(f_skip), .reps(f_reps), .drop(f_drop),
    .din(in_vec), .dout(faul_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      golden_vec <= '0;
      faulty_vec <= '0;
      mismatch   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      mismatch  <= in_valid && (gold_d != faul_d);
      if (in_valid) begin
        golden_vec <= gold_d;
        faulty_vec <= faul_d;
      end
    end
  end

endmodule

// File: rtl/revgate_cascade_chk.sv
module revgate_cascade_chk #(
  parameter int NL = 8,
  parameter int TGT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [NL-1:0]    cfg_ctrl_mask,
  input logic [TGT_W-1:0] cfg_target,
  input logic             flt_we,
  input logic [2:0]       flt_mode,
  input logic             in_valid,
  input logic             out_valid,
  input logic [NL-1:0]    golden_vec,
  input logic [NL-1:0]    faulty_vec,
  input logic             mismatch,
  input logic             config_error
);

  logic clean_q;
  always_ff @(posedge clk) begin
    if (rst) clean_q <= 1'b1;
    else if (flt_we) clean_q <= (flt_mode == 3'd0) || (flt_mode > 3'd4);
  end

  a_r3_reject_flags: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && cfg_ctrl_mask[cfg_target]) |-> config_error);

  a_r3_accept_clears: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && !cfg_ctrl_mask[cfg_target]) |-> !config_error);

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |-> out_valid);

  a_r4_no_valid_no_flag: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !mismatch);

  a_r4_flag_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mismatch == (golden_vec != faulty_vec)));

  a_r5_clean_equal: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(clean_q)) |-> !mismatch);

endmodule

bind revgate_cascade revgate_cascade_chk #(.NL(NL), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ctrl_mask(cfg_ctrl_mask),
  .cfg_target(cfg_target), .flt_we(flt_we), .flt_mode(flt_mode),
  .in_valid(in_valid), .out_valid(out_valid), .golden_vec(golden_vec),
  .faulty_vec(faulty_vec), .mismatch(mismatch), .config_error(config_error)
);

// File: tb/revgate_cascade_bench.sv
module revgate_cascade_bench;

  localparam int NL = 8;
  localparam int NG = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 0, cfg_enable = 0, flt_we = 0, in_valid = 0;
  logic [3:0] cfg_slot = 0, flt_gate = 0;
  logic [7:0] cfg_ctrl_mask = 0, flt_drop = 0, in_vec = 0;
  logic [2:0] cfg_target = 0, flt_mode = 0;
  logic [4:0] flt_param = 0;
  logic       out_valid, mismatch, config_error;
  logic [7:0] golden_vec, faulty_vec;

  always #10 clk = ~clk;

  revgate_cascade u_revgate_cascade (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_ctrl_mask(cfg_ctrl_mask), .cfg_target(cfg_target), .cfg_enable(cfg_enable),
    .flt_we(flt_we), .flt_mode(flt_mode), .flt_gate(flt_gate), .flt_param(flt_param),
    .flt_drop(flt_drop), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .golden_vec(golden_vec), .faulty_vec(faulty_vec),
    .mismatch(mismatch), .config_error(config_error)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R2";

  // Behavioural reference model
  logic [7:0] m_mask [NG];
  int         m_tgt  [NG];
  bit         m_en   [NG];
  int         m_mode, m_gate, m_par;
  logic [7:0] m_drop;
  bit         m_err, e_valid, e_mis;
  logic [7:0] e_gold, e_faul;

  function automatic logic [7:0] model_run(input logic [7:0] vin, input bit faulty);
    logic [7:0] v = vin;
    for (int g = 0; g < NG; g++) begin
      int n = 1;
      logic [7:0] cm = m_mask[g];
      if (!m_en[g]) continue;
      if (faulty) begin
        if (m_mode == 1 && g == m_gate) continue;
        if (m_mode == 2 && g == m_gate) n = (m_par < 2) ? 2 : (m_par > 4 ? 4 : m_par);
        if (m_mode == 3 && g == m_gate) cm = cm & ~m_drop;
        if (m_mode == 4 && g >= m_gate && g < m_gate + ((m_par < 2) ? 2 : m_par)) continue;
      end
      for (int r = 0; r < n; r++)
        if ((v & cm) == cm) v[m_tgt[g]] = ~v[m_tgt[g]];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        m_mask[g] = 0; m_tgt[g] = 0; m_en[g] = 0;
      end
      m_mode = 0; m_gate = 0; m_par = 0; m_drop = 0; m_err = 0;
      e_valid = 0; e_mis = 0; e_gold = 0; e_faul = 0;
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        e_gold = model_run(in_vec, 0);
        e_faul = model_run(in_vec, 1);
      end
      e_mis = in_valid && (e_gold != e_faul);
      if (cfg_we) begin
        m_err = cfg_ctrl_mask[cfg_target];
        if (!m_err) begin
          m_mask[cfg_slot] = cfg_ctrl_mask;
          m_tgt[cfg_slot]  = int'(cfg_target);
          m_en[cfg_slot]   = cfg_enable;
        end
      end
      if (flt_we) begin
        m_mode = int'(flt_mode); m_gate = int'(flt_gate);
        m_par = int'(flt_param); m_drop = flt_drop;
      end
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({tag, " out_valid R4"}, out_valid, e_valid);
      check("config_error R3", config_error, m_err);
      check({tag, " mismatch R4"}, mismatch, e_mis);
      if (e_valid) begin
        check({tag, " golden R10"}, golden_vec, e_gold);
        check({tag, " faulty"}, faulty_vec, e_faul);
      end
    end
  end

  task automatic write_gate(input int s, input logic [7:0] m, input int t, input bit en);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 4'(s); cfg_ctrl_mask = m; cfg_target = 3'(t); cfg_enable = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_fault(input int md, input int g, input int p, input logic [7:0] d);
    @(negedge clk);
    flt_we = 1; flt_mode = 3'(md); flt_gate = 4'(g); flt_param = 5'(p); flt_drop = d;
    @(negedge clk);
    flt_we = 0;
  endtask

  task automatic apply_one(input logic [7:0] v, output logic [7:0] g, output logic [7:0] f,
                           output logic m);
    @(negedge clk);
    in_valid = 1; in_vec = v;
    @(negedge clk);
    in_valid = 0;
    g = golden_vec; f = faulty_vec; m = mismatch;
  endtask

  task automatic sweep();
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      in_valid = 1; in_vec = 8'(v);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    logic [7:0] g, f;
    logic m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset out_valid R2", out_valid, 0);
    check("reset mismatch R2", mismatch, 0);
    check("reset config_error R2", config_error, 0);
    check("reset golden R2", golden_vec, 0);
    rst = 0;

    tag = "R2";
    apply_one(8'h5A, g, f, m);
    check("empty chain passes R2", g, 8'h5A);

    // Fixed chain
    write_gate(0, 8'h06, 0, 1);
    write_gate(1, 8'h00, 7, 1);
    write_gate(2, 8'h01, 3, 1);
    write_gate(3, 8'h30, 6, 1);
    write_gate(4, 8'h01, 1, 0);
    write_gate(5, 8'h81, 2, 1);
    write_gate(6, 8'h04, 2, 1);
    check("overlap rejected R3", config_error, 1);
    tag = "R1";
    apply_one(8'h06, g, f, m);
    check("chain result R1", g, 8'h8B);
    check("no fault equal R5", f, 8'h8B);
    write_gate(7, 8'h00, 4, 0);
    check("accepted write clears R3", config_error, 0);

    set_fault(1, 0, 0, 0);
    tag = "R6";
    apply_one(8'h06, g, f, m);
    check("gate removed R6", f, 8'h86);
    check("golden untouched R10", g, 8'h8B);
    check("removed gate mismatch R4", m, 1);

    tag = "R5";  set_fault(0, 0, 0, 0);  sweep();
    tag = "R5";  set_fault(6, 2, 3, 8'hFF); sweep();
    tag = "R6";  set_fault(1, 5, 0, 0);  sweep();
    tag = "R7";  set_fault(2, 2, 2, 0);  sweep();
    tag = "R7";  set_fault(2, 2, 3, 0);  sweep();
    tag = "R7";  set_fault(2, 5, 4, 0);  sweep();
    tag = "R7";  set_fault(2, 0, 1, 0);  sweep();
    tag = "R7";  set_fault(2, 0, 7, 0);  sweep();
    tag = "R8";  set_fault(3, 5, 0, 8'h80); sweep();
    tag = "R8";  set_fault(3, 0, 0, 8'h06); sweep();
    tag = "R9";  set_fault(4, 1, 3, 0);  sweep();
    tag = "R9";  set_fault(4, 0, 0, 0);  sweep();

    // Random chains
    for (int it = 0; it < 12; it++) begin
      for (int s = 0; s < NG; s++) begin
        int t = $urandom_range(0, 7);
        logic [7:0] mk = 8'($urandom) & ~(8'(1) << t);
        if ($urandom_range(0, 2) == 0) mk = mk & 8'($urandom);
        write_gate(s, mk, t, $urandom_range(0, 4) != 0);
      end
      write_gate(3, 8'h08, 3, 1);
      tag = "R3";
      case (it % 6)
        0: begin tag = "R6"; set_fault(1, $urandom_range(0, 15), 0, 0); end
        1: begin tag = "R7"; set_fault(2, $urandom_range(0, 15), $urandom_range(0, 9), 0); end
        2: begin tag = "R8"; set_fault(3, $urandom_range(0, 15), 0, 8'($urandom)); end
        3: begin tag = "R9"; set_fault(4, 14, 5, 0); end
        4: begin tag = "R9"; set_fault(4, $urandom_range(0, 15), $urandom_range(0, 20), 0); end
        default: begin tag = "R1"; set_fault(0, 0, 0, 0); end
      endcase
      sweep();
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule